// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between locations on a 20-bit, byte-addressed memory bus on behalf of software. It has two independent channels. Each request a channel accepts becomes exactly one unit transfer: one read from the source address, then one write of the same data to the destination address. A unit is 8 or 16 bits wide, chosen per channel. The controller takes the bus for just that unit and then releases it. This is cycle stealing.

Software sets up each channel through a small register port. The settings are a source pointer, a destination pointer, a reload value for the 16-bit transfer counter, and a control word. The control word holds enable, width, repeat, the direction of each side (fixed or forward) and the request source. Requests come from a software trigger bit, from the external pin (falling edge only, or both edges), or from one of four peripheral request pulses. A request that arrives while a unit is in flight is held as pending. When a channel's counter runs past zero, the channel pulses its interrupt line. In single mode the channel then turns itself off. In repeat mode it reloads the counter and keeps running.

The memory side is a valid/ready stream. The controller raises `mem_valid` with address, direction and width. It holds every one of them unchanged until `mem_ready` is seen high on a rising clock edge. Read data must be valid in the same cycle as the read handshake. The memory may stall either phase for any number of cycles.

Top module: `dma2ch`

## Requirements
- R1: Each accepted request produces one read handshake at the channel's current source address, followed by one write handshake at its current destination address. In 16-bit mode (control bit 1 = 1) the written data is the full 16-bit read word. In 8-bit mode the written data is the low byte of the read word, zero-extended. `mem_wide` shows the unit size.
- R2: When both channels have a request pending in the same idle cycle, channel 0 is served first, and channel 1 is served after it.
- R3: The forward-side pointer advances by 1 after each 8-bit unit and by 2 after each 16-bit unit. A fixed-side address never changes. Control bit 3 = 1 makes the source forward. Control bit 4 = 1 makes the destination forward.
- R4: If both control bits 3 and 4 are 1, only the source advances and the destination stays fixed.
- R5: The working counter and the working forward pointer are loaded from the reload register and the forward-side register at the first unit after the channel is enabled. A run therefore moves reload+1 units.
- R6: In single mode (control bit 2 = 0), the unit that takes the counter past zero clears the enable bit (control bit 0). Later requests then cause no bus activity.
- R7: In repeat mode (control bit 2 = 1), the counter is reloaded at underflow and the enable bit stays 1. The forward pointer keeps advancing across runs.
- R8: A channel's `irq` bit is high for exactly one cycle. That cycle is the one right after the write handshake of the unit that underflowed the counter. The two `irq` bits are never high together.
- R9: While a channel is enabled, writes to its fixed-side pointer register are ignored. The forward-side pointer register, the reload register and the control register can be written at any time.
- R10: While a channel is enabled, reading its forward-side pointer register returns the live working pointer. When the channel is disabled, the read returns the stored register value.
- R11: The request source is set by control bits 7:5, and a request for a disabled channel is ignored. The codes are: 0 none; 1 software trigger (write 1 to bit 0 of register index 5); 2 external pin falling edge; 3 external pin either edge; 4 to 7 peripheral request lines 0 to 3. A request that arrives while a unit is in flight is kept as pending and served later.
- R12: After reset the bus is idle and every control register reads 0. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_we` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bit 3 selects the channel. Bits 2:0 select the index: 0 source, 1 destination, 2 reload, 3 control, 4 live counter, 5 trigger |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data, combinational from reg_addr |
| ext_pin | input | 1 | External request pin, idles high |
| periph_req | input | 4 | Peripheral request pulses |
| mem_valid | output | 1 | Bus request valid |
| mem_ready | input | 1 | Bus accepts the current phase |
| mem_we | output | 1 | 1 for the write phase, 0 for the read phase |
| mem_wide | output | 1 | 1 for a 16-bit unit |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid during the read handshake |
| irq | output | 2 | Per-channel underflow pulse |

## Verification
Two things can fall in the same cycle: the write handshake that finishes one unit, and a new request arriving. A related case is two requests arriving in the same idle cycle, one on each channel. The bench provokes the first case by firing two software triggers a few cycles apart, so the second lands while the first unit is still in flight. It expects exactly two write handshakes. It provokes the second case with one falling edge on the pin while both channels select that pin, and it expects channel 0's destination address to appear before channel 1's in the write log.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam int SEL_W  = 3;
  localparam int NPER   = 4;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] RI_SRC = 3'd0;
  localparam logic [IDX_W-1:0] RI_DST = 3'd1;
  localparam logic [IDX_W-1:0] RI_RLD = 3'd2;
  localparam logic [IDX_W-1:0] RI_CTL = 3'd3;
  localparam logic [IDX_W-1:0] RI_CNT = 3'd4;
  localparam logic [IDX_W-1:0] RI_TRG = 3'd5;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             dst_fwd;
    logic             src_fwd;
    logic             rpt;
    logic             wide;
    logic             en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_t;
endpackage

// File: rtl/dma2ch_reqsel.sv
module dma2ch_reqsel
  import dma2ch_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_pin,
  input  logic [NPER-1:0]      periph_req,
  input  logic [NCH-1:0]       sw_trig,
  input  logic [NCH*SEL_W-1:0] sel_flat,
  output logic [NCH-1:0]       req_ev
);
  logic pin_q;
  logic pin_fall, pin_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= ext_pin;
  end

  assign pin_fall = pin_q & ~ext_pin;
  assign pin_any  = pin_q ^ ext_pin;

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    logic [SEL_W-1:0] s;
    assign s = sel_flat[c*SEL_W +: SEL_W];
    always_comb begin
      case (s)
        3'd0:    req_ev[c] = 1'b0;
        3'd1:    req_ev[c] = sw_trig[c];
        3'd2:    req_ev[c] = pin_fall;
        3'd3:    req_ev[c] = pin_any;
        default: req_ev[c] = periph_req[s[SEL_W-2:0]];
      endcase
    end
  end
endmodule

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [AW-1:0]    wdata,
  output logic [AW-1:0]    rd_data,
  input  logic             req_ev,
  input  logic             grant,
  input  logic             done,
  output logic             pend,
  output logic [AW-1:0]    cur_src,
  output logic [AW-1:0]    cur_dst,
  output logic             wide,
  output logic [SEL_W-1:0] sel,
  output logic             sw_trig,
  output logic             irq
);
  ctrl_t         ctl;
  logic [AW-1:0] src_r, dst_r, fptr;
  logic [CW-1:0] rld, cnt;
  logic          started, pend_r;
  logic          src_fwd_e, dst_fwd_e;
  logic [AW-1:0] fwd_reg, ptr_cur, step;

  assign src_fwd_e = ctl.src_fwd;
  assign dst_fwd_e = ctl.dst_fwd & ~ctl.src_fwd;
  assign fwd_reg   = src_fwd_e ? src_r : dst_r;
  assign ptr_cur   = started ? fptr : fwd_reg;
  assign cur_src   = src_fwd_e ? ptr_cur : src_r;
  assign cur_dst   = dst_fwd_e ? ptr_cur : dst_r;
  assign step      = ctl.wide ? AW'(2) : AW'(1);
  assign wide      = ctl.wide;
  assign sel       = ctl.sel;
  assign pend      = pend_r & ctl.en;
  assign sw_trig   = wr_en && (idx == RI_TRG) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      src_r   <= '0;
      dst_r   <= '0;
      fptr    <= '0;
      rld     <= '0;
      cnt     <= '0;
      started <= 1'b0;
      pend_r  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq    <= 1'b0;
      pend_r <= ctl.en & ((pend_r & ~grant) | req_ev);
      if (grant && !started) begin
        fptr    <= fwd_reg;
        cnt     <= rld;
        started <= 1'b1;
      end
      if (done) begin
        fptr <= fptr + step;
        if (cnt == '0) begin
          irq <= 1'b1;
          if (ctl.rpt) cnt <= rld;
          else begin
            ctl.en  <= 1'b0;
            started <= 1'b0;
          end
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
      if (wr_en) begin
        case (idx)
          RI_SRC: if (!ctl.en || src_fwd_e) src_r <= wdata;
          RI_DST: if (!ctl.en || dst_fwd_e) dst_r <= wdata;
          RI_RLD: rld <= wdata[CW-1:0];
          RI_CTL: begin
            ctl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
            if (!wdata[0] || !ctl.en) started <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      RI_SRC:  rd_data = (ctl.en && src_fwd_e) ? ptr_cur : src_r;
      RI_DST:  rd_data = (ctl.en && dst_fwd_e) ? ptr_cur : dst_r;
      RI_RLD:  rd_data = AW'(rld);
      RI_CTL:  rd_data = AW'(ctl);
      RI_CNT:  rd_data = AW'(cnt);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
  import dma2ch_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pend,
  input  logic [NCH*AW-1:0] cur_src,
  input  logic [NCH*AW-1:0] cur_dst,
  input  logic [NCH-1:0]    wide,
  output logic [NCH-1:0]    grant,
  output logic [NCH-1:0]    done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  eng_st_t        st;
  logic [CHW-1:0] ch_q, gidx;
  logic [AW-1:0]  a_src, a_dst;
  logic           wd_q;
  logic [DW-1:0]  data_q;

  always_comb begin
    grant = '0;
    gidx  = '0;
    if (st == ST_IDLE) begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (pend[c]) begin
          grant    = '0;
          grant[c] = 1'b1;
          gidx     = CHW'(c);
        end
      end
    end
  end

  always_comb begin
    done = '0;
    if (st == ST_WR && mem_ready) done[ch_q] = 1'b1;
  end

  assign mem_valid = (st != ST_IDLE);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? a_dst : a_src;
  assign mem_wdata = data_q;
  assign mem_wide  = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ch_q   <= '0;
      a_src  <= '0;
      a_dst  <= '0;
      wd_q   <= 1'b0;
      data_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (|grant) begin
          ch_q  <= gidx;
          a_src <= cur_src[gidx*AW +: AW];
          a_dst <= cur_dst[gidx*AW +: AW];
          wd_q  <= wide[gidx];
          st    <= ST_RD;
        end
        ST_RD: if (mem_ready) begin
          data_q <= wd_q ? mem_rdata : DW'(mem_rdata[DW/2-1:0]);
          st     <= ST_WR;
        end
        ST_WR: if (mem_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [IDX_W:0]        reg_addr,
  input  logic [AW-1:0]         reg_wdata,
  output logic [AW-1:0]         reg_rdata,
  input  logic                  ext_pin,
  input  logic [NPER-1:0]       periph_req,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_we,
  output logic                  mem_wide,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic [NCH-1:0]        irq
);
  logic [NCH-1:0]       pend_v, grant_v, done_v, req_ev, sw_trig, wide_v;
  logic [NCH*AW-1:0]    src_v, dst_v, rd_v;
  logic [NCH*SEL_W-1:0] sel_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c;
    assign wr_c = reg_wr && (reg_addr[IDX_W] == c[0]);
    dma2ch_chan #(.AW(AW), .CW(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_c),
      .idx     (reg_addr[IDX_W-1:0]),
      .wdata   (reg_wdata),
      .rd_data (rd_v[c*AW +: AW]),
      .req_ev  (req_ev[c]),
      .grant   (grant_v[c]),
      .done    (done_v[c]),
      .pend    (pend_v[c]),
      .cur_src (src_v[c*AW +: AW]),
      .cur_dst (dst_v[c*AW +: AW]),
      .wide    (wide_v[c]),
      .sel     (sel_v[c*SEL_W +: SEL_W]),
      .sw_trig (sw_trig[c]),
      .irq     (irq[c])
    );
  end

  assign reg_rdata = rd_v[reg_addr[IDX_W]*AW +: AW];

  dma2ch_reqsel #(.NCH(NCH)) u_reqsel (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_pin    (ext_pin),
    .periph_req (periph_req),
    .sw_trig    (sw_trig),
    .sel_flat   (sel_v),
    .req_ev     (req_ev)
  );

  dma2ch_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_v),
    .cur_src   (src_v),
    .cur_dst   (dst_v),
    .wide      (wide_v),
    .grant     (grant_v),
    .done      (done_v),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk #(
  parameter int NCH = 2,
  parameter int AW  = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] grant
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R12

  AST_CH0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && pend[1] && (|grant)) |-> grant[0]); // R2

  AST_IRQ_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> $past(mem_valid && mem_ready && mem_we)); // R8

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq)); // R8

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_valid && mem_ready && !mem_we)); // R1
endmodule

bind dma2ch dma2ch_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .irq       (irq),
  .pend      (pend_v),
  .grant     (grant_v)
);

// File: tb/dma2ch_tb.sv
`timescale 1ns/1ps
module dma2ch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic        ext_pin = 1'b1;
  logic [3:0]  periph_req = '0;
  logic        mem_valid, mem_ready, mem_we, mem_wide;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0]  irq;

  always #2 clk = ~clk;

  dma2ch u_dut (.*);

  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h5, a[19:16]};
  endfunction

  always_comb mem_rdata = {mb(mem_addr + 20'd1), mb(mem_addr)};

  logic [7:0] lf = 8'hA5;
  always @(negedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  assign mem_ready = lf[0] | lf[2];

  logic [19:0] wlog_a [64];
  logic [15:0] wlog_d [64];
  logic [19:0] rlog_a [64];
  int wcnt = 0, rcnt = 0;
  int irqc0 = 0, irqc1 = 0;
  logic        hold_pend = 1'b0;
  logic [19:0] hold_a;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_pend) chk("R12 bus hold", {11'd0, mem_valid, mem_addr}, {11'd0, 1'b1, hold_a});
      hold_pend <= mem_valid && !mem_ready;
      hold_a    <= mem_addr;
      if (mem_valid && mem_ready && mem_we) begin
        wlog_a[wcnt % 64] <= mem_addr;
        wlog_d[wcnt % 64] <= mem_wdata;
        wcnt <= wcnt + 1;
      end
      if (mem_valid && mem_ready && !mem_we) begin
        rlog_a[rcnt % 64] <= mem_addr;
        rcnt <= rcnt + 1;
      end
      if (irq[0]) irqc0 <= irqc0 + 1;
      if (irq[1]) irqc1 <= irqc1 + 1;
    end
  end

  task automatic wreg(input logic ch, input logic [2:0] idx, input logic [19:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {ch, idx}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic ch, input logic [2:0] idx, output logic [19:0] d);
    @(negedge clk);
    reg_addr = {ch, idx};
    #1 d = reg_rdata;
  endtask

  task automatic wait_w(input int target);
    for (int i = 0; i < 400 && wcnt < target; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [19:0] ctlw(input logic [2:0] sel, input logic df, input logic sf,
                                       input logic rp, input logic wd, input logic en);
    return {12'd0, sel, df, sf, rp, wd, en};
  endfunction

  task automatic chk_unit(input string tag, input int i, input logic [19:0] es,
                          input logic [19:0] ed, input logic wd);
    logic [15:0] exp_d;
    exp_d = wd ? {mb(es + 20'd1), mb(es)} : {8'h00, mb(es)};
    chk({tag, " read addr"},  {12'd0, rlog_a[i % 64]}, {12'd0, es});
    chk({tag, " write addr"}, {12'd0, wlog_a[i % 64]}, {12'd0, ed});
    chk({tag, " write data"}, {16'd0, wlog_d[i % 64]}, {16'd0, exp_d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] rd;
    int base, ib;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R12 reset state
    rreg(1'b0, 3'd3, rd); chk("R12 reset ctl0", {12'd0, rd}, 32'd0);
    rreg(1'b1, 3'd3, rd); chk("R12 reset ctl1", {12'd0, rd}, 32'd0);
    chk("R12 reset bus idle", {30'd0, mem_valid, irq[0]}, 32'd0);

    // Sweep: width x direction config x reload, channel 0, single mode (R1 R3 R4 R5 R6 R8 R10)
    for (int w = 0; w < 2; w++) begin
      for (int fm = 0; fm < 4; fm++) begin
        for (int rl = 0; rl < 3; rl++) begin
          logic sf, df, dfe;
          logic [19:0] s0, d0, step;
          sf = fm[0]; df = fm[1]; dfe = df & ~sf;
          step = w ? 20'd2 : 20'd1;
          s0 = 20'h10000 + 20'(w * 512 + fm * 64 + rl * 16);
          d0 = 20'h2A300 + 20'(w * 512 + fm * 64 + rl * 16);
          wreg(1'b0, 3'd0, s0);
          wreg(1'b0, 3'd1, d0);
          wreg(1'b0, 3'd2, 20'(rl));
          ib = irqc0;
          wreg(1'b0, 3'd3, ctlw(3'd1, df, sf, 1'b0, w[0], 1'b1));
          for (int k = 0; k <= rl; k++) begin
            base = wcnt;
            wreg(1'b0, 3'd5, 20'd1);
            wait_w(base + 1);
            chk_unit("R1 R3 R4 R5 unit", base,
                     sf ? s0 + 20'(k) * step : s0,
                     dfe ? d0 + 20'(k) * step : d0, w[0]);
            if (k < rl && (sf || dfe)) begin
              rreg(1'b0, sf ? 3'd0 : 3'd1, rd);
              chk("R10 live pointer", {12'd0, rd}, {12'd0, (sf ? s0 : d0) + 20'(k + 1) * step});
            end
          end
          idle(3);
          chk("R8 one irq per run", irqc0, ib + 1);
          rreg(1'b0, 3'd3, rd);
          chk("R6 enable cleared", {31'd0, rd[0]}, 32'd0);
          base = wcnt;
          wreg(1'b0, 3'd5, 20'd1);
          idle(20);
          chk("R6 R5 no unit after run", wcnt, base);
        end
      end
    end

    // R9 write lock on fixed side, forward side writable (channel 1: src fixed, dst forward)
    wreg(1'b1, 3'd0, 20'h30000);
    wreg(1'b1, 3'd1, 20'h40000);
    wreg(1'b1, 3'd2, 20'd5);
    wreg(1'b1, 3'd3, ctlw(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    wreg(1'b1, 3'd0, 20'h3ABCD);
    rreg(1'b1, 3'd0, rd); chk("R9 fixed side locked", {12'd0, rd}, 32'h30000);
    wreg(1'b1, 3'd1, 20'h4FF00);
    rreg(1'b1, 3'd1, rd); chk("R9 forward side writable", {12'd0, rd}, 32'h4FF00);
    base = wcnt;
    wreg(1'b1, 3'd5, 20'd1);
    wait_w(base + 1);
    chk_unit("R9 unit", base, 20'h30000, 20'h4FF00, 1'b0);
    rreg(1'b1, 3'd1, rd); chk("R10 live dst pointer", {12'd0, rd}, 32'h4FF01);
    wreg(1'b1, 3'd3, ctlw(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    rreg(1'b1, 3'd1, rd); chk("R10 stored dst when disabled", {12'd0, rd}, 32'h4FF00);
    wreg(1'b1, 3'd0, 20'h3ABCD);
    rreg(1'b1, 3'd0, rd); chk("R9 fixed writable when disabled", {12'd0, rd}, 32'h3ABCD);

    // R7 repeat mode: reload 1, 16-bit, source forward
    wreg(1'b0, 3'd0, 20'h05000);
    wreg(1'b0, 3'd1, 20'h06000);
    wreg(1'b0, 3'd2, 20'd1);
    ib = irqc0;
    wreg(1'b0, 3'd3, ctlw(3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    for (int k = 0; k < 5; k++) begin
      base = wcnt;
      wreg(1'b0, 3'd5, 20'd1);
      wait_w(base + 1);
      chk_unit("R7 repeat unit", base, 20'h05000 + 20'(2 * k), 20'h06000, 1'b1);
      idle(3);
      chk("R7 R8 irq count", irqc0, ib + (k + 1) / 2);
    end
    rreg(1'b0, 3'd3, rd); chk("R7 enable stays", {31'd0, rd[0]}, 32'd1);
    wreg(1'b0, 3'd3, 20'd0);

    // R2 priority: both channels on pin falling edge
    wreg(1'b0, 3'd0, 20'h07000); wreg(1'b0, 3'd1, 20'h07100); wreg(1'b0, 3'd2, 20'd9);
    wreg(1'b1, 3'd0, 20'h08000); wreg(1'b1, 3'd1, 20'h08100); wreg(1'b1, 3'd2, 20'd9);
    wreg(1'b0, 3'd3, ctlw(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    wreg(1'b1, 3'd3, ctlw(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    base = wcnt;
    @(negedge clk) ext_pin = 1'b0;
    wait_w(base + 2);
    chk("R2 channel 0 first", {12'd0, wlog_a[base % 64]}, 32'h07100);
    chk("R2 channel 1 second", {12'd0, wlog_a[(base + 1) % 64]}, 32'h08100);
    base = wcnt;
    @(negedge clk) ext_pin = 1'b1;
    idle(20);
    chk("R11 rising edge ignored by fall-only", wcnt, base);

    // R11 either-edge on channel 1 only
    wreg(1'b0, 3'd3, 20'd0);
    wreg(1'b1, 3'd3, ctlw(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    base = wcnt;
    @(negedge clk) ext_pin = 1'b0;
    idle(20);
    chk("R11 either-edge on fall", wcnt, base + 1);
    @(negedge clk) ext_pin = 1'b1;
    idle(20);
    chk("R11 either-edge on rise", wcnt, base + 2);
    chk("R11 either-edge dst", {12'd0, wlog_a[(base + 1) % 64]}, 32'h08100);

    // R11 peripheral line 2 (code 6)
    wreg(1'b1, 3'd3, ctlw(3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    base = wcnt;
    @(negedge clk) periph_req = 4'b0100;
    @(negedge clk) periph_req = 4'b0000;
    idle(20);
    chk("R11 selected peripheral line", wcnt, base + 1);
    @(negedge clk) periph_req = 4'b0010;
    @(negedge clk) periph_req = 4'b0000;
    idle(20);
    chk("R11 other peripheral line ignored", wcnt, base + 1);
    wreg(1'b1, 3'd3, 20'd0);

    // R11 disabled channel ignores trigger
    base = wcnt;
    wreg(1'b0, 3'd5, 20'd1);
    idle(20);
    chk("R11 disabled ignores trigger", wcnt, base);

    // R11 request during a unit is kept pending
    wreg(1'b0, 3'd0, 20'h09000); wreg(1'b0, 3'd1, 20'h09100); wreg(1'b0, 3'd2, 20'd5);
    wreg(1'b0, 3'd3, ctlw(3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    base = wcnt;
    wreg(1'b0, 3'd5, 20'd1);
    wreg(1'b0, 3'd5, 20'd1);
    idle(40);
    chk("R11 pending request served", wcnt, base + 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule